// File: doc/BRIEF.md
# FMA Addend Alignment Shifter

This block prepares the addend significand of a double-precision fused multiply-add, A + B×C, while the multiplier is still working on B×C. The product is kept at a fixed place in a 161-bit field and only the addend moves. The block works out the exponent difference from the three biased exponents. It shifts the 53-bit addend (hidden bit included) left or right to the matching position, and it inverts the field when the operation is an effective subtraction. The result is registered once, so it arrives one cycle after the operands, next to the carry-save product.

Two flags come out with the field. `prod_below` says the product lies wholly under the addend's least significant bit, so downstream logic uses the product only for the sticky bit. `addend_sticky` is the OR of the addend bits pushed out below bit 0 of the field.

Top module: `fma_addend_align`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid`, `prod_below`, `addend_sticky` and every bit of `aligned_addend` are 0.
- R2: The outputs take the values computed from the operands that `in_valid` accepted at the previous rising clock edge, and `out_valid` equals `in_valid` delayed by one cycle. When `in_valid` is low, `aligned_addend`, `prod_below` and `addend_sticky` keep their values whatever the other inputs do.
- R3: The exponent difference is d = exp_addend − exp_mul_a − exp_mul_b + 1023. It is evaluated without wraparound over the full range of 11-bit exponents, so every value from −3071 to +3070 is handled.
- R4: For 0 ≤ d < 56, addend bit j appears at field bit 50 + d + j. A larger d moves the addend toward the MSB of the field.
- R5: For d ≥ 56, the shift saturates. Addend bit j appears at field bit 106 + j, and `prod_below` is 1. For every d < 56, `prod_below` is 0.
- R6: For d < 0, addend bit j appears at field bit 50 + d + j whenever that index is 0 or more. When d ≤ −105, no addend bit remains in the field.
- R7: `addend_sticky` is the OR of the addend bits whose index 50 + d + j would be below 0. It is computed before any inversion.
- R8: When `eff_sub` is 1, all 161 bits of `aligned_addend` are the one's complement of the field that R4 to R6 describe. `prod_below` and `addend_sticky` are not affected by `eff_sub`.
- R9: Before inversion, field bits 160 and 159 are always 0. After inversion, the two bits are equal to each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| in_valid | input | 1 | Operands valid; acts as the clock enable of the output register |
| addend_sig | input | 53 | Addend significand including the hidden bit |
| exp_addend | input | 11 | Biased exponent of the addend |
| exp_mul_a | input | 11 | Biased exponent of the first multiplicand |
| exp_mul_b | input | 11 | Biased exponent of the second multiplicand |
| eff_sub | input | 1 | 1 for an effective subtraction: invert the aligned field |
| out_valid | output | 1 | Registered outputs hold a new result |
| aligned_addend | output | 161 | Aligned and optionally inverted addend field |
| prod_below | output | 1 | Product lies wholly below the addend LSB; it affects only the sticky bit |
| addend_sticky | output | 1 | OR of the addend bits shifted out below field bit 0 |

## Verification
The block has only one register stage, so any error in the exponent difference, the clamping or a single barrel stage shows up in `aligned_addend` one cycle after the operands are accepted.

- A stage that fails to shift moves the addend by a power of two. The check compares the whole field against a bit-by-bit placement model, so this shows up at once.
- A difference that wraps at the exponent extremes turns an all-out right shift into a saturated left one. That flips `prod_below` and `addend_sticky` in the same cycle.
- A missing inversion flips all 161 bits.
- A broken clock enable shows up as a field that changes while `in_valid` is low.

// File: rtl/fma_align_pkg.sv
package fma_align_pkg;
  localparam int SIG_W     = 53;
  localparam int EXP_W     = 11;
  localparam int EXP_BIAS  = 1023;
  localparam int PROD_W    = 106;
  localparam int LEFT_MAX  = 56;
  localparam int RIGHT_MAX = 105;
  localparam int WIN_W     = LEFT_MAX + RIGHT_MAX;
  localparam int SH_W      = $clog2(WIN_W + 1);
  localparam int DIFF_W    = EXP_W + 2;
endpackage

// File: rtl/fma_rst_sync.sv
module fma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fma_exp_diff.sv
module fma_exp_diff
  import fma_align_pkg::*;
#(
  parameter int EW      = EXP_W,
  parameter int BIAS    = EXP_BIAS,
  parameter int LMAX    = LEFT_MAX,
  parameter int WW      = WIN_W,
  parameter int SW      = SH_W
) (
  input  logic [EW-1:0] exp_addend,
  input  logic [EW-1:0] exp_mul_a,
  input  logic [EW-1:0] exp_mul_b,
  output logic [SW-1:0] shift_amt,
  output logic          far_left
);
  localparam int DW = EW + 2;

  logic signed [DW-1:0] diff;
  logic signed [DW-1:0] rshift;

  always_comb begin
    diff   = $signed({2'b00, exp_addend}) - $signed({2'b00, exp_mul_a})
           - $signed({2'b00, exp_mul_b}) + $signed(DW'(BIAS));
    rshift = $signed(DW'(LMAX)) - diff;
    far_left  = 1'b0;
    shift_amt = '0;
    if (diff >= $signed(DW'(LMAX))) begin
      far_left  = 1'b1;
      shift_amt = '0;
    end else if (rshift >= $signed(DW'(WW))) begin
      shift_amt = SW'(WW);
    end else begin
      shift_amt = rshift[SW-1:0];
    end
  end
endmodule

// File: rtl/fma_barrel_rshift.sv
module fma_barrel_rshift #(
  parameter int WW = 161,
  parameter int SW = 8
) (
  input  logic [WW-1:0] din,
  input  logic [SW-1:0] amt,
  output logic [WW-1:0] dout,
  output logic          lost
);
  localparam int EXT_W = 2 * WW;

  logic [EXT_W-1:0] stg [SW+1];

  assign stg[0] = {din, {WW{1'b0}}};

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int AMT = 1 << k;
    assign stg[k+1] = amt[k] ? {{AMT{1'b0}}, stg[k][EXT_W-1:AMT]} : stg[k];
  end

  assign dout = stg[SW][EXT_W-1:WW];
  assign lost = |stg[SW][WW-1:0];
endmodule

// File: rtl/fma_addend_align.sv
module fma_addend_align
  import fma_align_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SIG_W-1:0]   addend_sig,
  input  logic [EXP_W-1:0]   exp_addend,
  input  logic [EXP_W-1:0]   exp_mul_a,
  input  logic [EXP_W-1:0]   exp_mul_b,
  input  logic               eff_sub,
  output logic               out_valid,
  output logic [WIN_W-1:0]   aligned_addend,
  output logic               prod_below,
  output logic               addend_sticky
);
  localparam int TOP_PAD = WIN_W - SIG_W - PROD_W;

  logic             rst_sync_n;
  logic [SH_W-1:0]  shift_amt;
  logic             far_left;
  logic [WIN_W-1:0] placed;
  logic [WIN_W-1:0] shifted;
  logic             lost;

  logic             valid_d;
  logic [WIN_W-1:0] field_d;
  logic             below_d;
  logic             sticky_d;

  fma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fma_exp_diff u_diff (
    .exp_addend (exp_addend),
    .exp_mul_a  (exp_mul_a),
    .exp_mul_b  (exp_mul_b),
    .shift_amt  (shift_amt),
    .far_left   (far_left)
  );

  assign placed = {{TOP_PAD{1'b0}}, addend_sig, {PROD_W{1'b0}}};

  fma_barrel_rshift #(.WW(WIN_W), .SW(SH_W)) u_shift (
    .din  (placed),
    .amt  (shift_amt),
    .dout (shifted),
    .lost (lost)
  );

  always_comb begin
    valid_d  = in_valid;
    field_d  = shifted ^ {WIN_W{eff_sub}};
    below_d  = far_left;
    sticky_d = lost;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid      <= 1'b0;
      aligned_addend <= '0;
      prod_below     <= 1'b0;
      addend_sticky  <= 1'b0;
    end else begin
      out_valid <= valid_d;
      if (in_valid) begin
        aligned_addend <= field_d;
        prod_below     <= below_d;
        addend_sticky  <= sticky_d;
      end
    end
  end
endmodule

// File: rtl/fma_align_checker.sv
module fma_align_checker
  import fma_align_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [WIN_W-1:0] aligned_addend,
  input logic             prod_below,
  input logic             addend_sticky
);
  // R2: the valid flag follows the accepted-operand strobe by one cycle
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R2: no accepted operands, no change to the held result
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(aligned_addend) && $stable(prod_below) && $stable(addend_sticky)));

  // R5: saturated left shift leaves the product region free of addend bits
  a_r5_prod_region_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prod_below) |->
      ((aligned_addend[PROD_W-1:0] == '0) || (aligned_addend[PROD_W-1:0] == '1)));

  // R7: a saturated left shift drops nothing
  a_r7_no_loss_when_far: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prod_below) |-> !addend_sticky);

  // R9: the two guard bits at the top are always equal
  a_r9_top_pad: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (aligned_addend[WIN_W-1] == aligned_addend[WIN_W-2]));

  // R8: the field holds at most one significand of ones, or its complement does
  a_r8_population: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($countones(aligned_addend) <= SIG_W) ||
                   ($countones(~aligned_addend) <= SIG_W)));
endmodule

bind fma_addend_align fma_align_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .in_valid       (in_valid),
  .out_valid      (out_valid),
  .aligned_addend (aligned_addend),
  .prod_below     (prod_below),
  .addend_sticky  (addend_sticky)
);

// File: tb/test_fma_addend_align.sv
module test_fma_addend_align;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [52:0]  addend_sig;
  logic [10:0]  exp_addend, exp_mul_a, exp_mul_b;
  logic         eff_sub;
  logic         out_valid;
  logic [160:0] aligned_addend;
  logic         prod_below;
  logic         addend_sticky;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fma_addend_align i_fma_addend_align (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addend_sig(addend_sig),
    .exp_addend(exp_addend), .exp_mul_a(exp_mul_a), .exp_mul_b(exp_mul_b),
    .eff_sub(eff_sub), .out_valid(out_valid), .aligned_addend(aligned_addend),
    .prod_below(prod_below), .addend_sticky(addend_sticky)
  );

  // stimulus columns plus the hand-computed exponent difference (R3)
  localparam logic [10:0] T_EA [NV] = '{11'd1023, 11'd1078, 11'd1079, 11'd1323, 11'd1022, 11'd963,
                                        11'd919,  11'd918,  11'd0,    11'd2047, 11'd1033, 11'd823};
  localparam logic [10:0] T_EB [NV] = '{11'd1023, 11'd1023, 11'd1023, 11'd1023, 11'd1023, 11'd1023,
                                        11'd1023, 11'd1023, 11'd2047, 11'd0,    11'd1023, 11'd1023};
  localparam logic [10:0] T_EC [NV] = '{11'd1023, 11'd1023, 11'd1023, 11'd1023, 11'd1023, 11'd1023,
                                        11'd1023, 11'd1023, 11'd2047, 11'd0,    11'd1023, 11'd1023};
  localparam logic [52:0] T_SIG [NV] = '{53'h1FFFFFFFFFFFFF, 53'h10000000000001, 53'h1ABCDEF0123457,
                                         53'h10000000000000, 53'h15555555555555, 53'h10000000000008,
                                         53'h1FFFFFFFFFFFFF, 53'h10000000000000, 53'h10000000000001,
                                         53'h1FFFFFFFFFFFFF, 53'h13333333333333, 53'h10000000000000};
  localparam logic T_SUB [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int T_D [NV] = '{0, 55, 56, 300, -1, -60, -104, -105, -3071, 3070, 10, -200};

  function automatic void model(input logic [52:0] s, input int d, input logic sub,
                                output logic [160:0] f, output logic st, output logic far);
    int dm;
    f = '0; st = 1'b0;
    far = (d >= 56);
    dm = (d > 56) ? 56 : d;
    for (int j = 0; j < 53; j++) begin
      int pos;
      pos = 50 + dm + j;
      if (pos >= 0) f[pos] = s[j];
      else st = st | s[j];
    end
    if (sub) f = ~f;
  endfunction

  task automatic check1(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic check_field(input string req, input logic [160:0] got, input logic [160:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input int i);
    @(negedge clk);
    addend_sig = T_SIG[i]; exp_addend = T_EA[i]; exp_mul_a = T_EB[i];
    exp_mul_b = T_EC[i]; eff_sub = T_SUB[i]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [160:0] ef;
    logic est, efar;
    logic [160:0] held;
    rst_n = 1'b0; in_valid = 1'b0; addend_sig = '0; exp_addend = '0;
    exp_mul_a = '0; exp_mul_b = '0; eff_sub = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1 out_valid", out_valid, 1'b0);
    check_field("R1 field", aligned_addend, '0);
    check1("R1 prod_below", prod_below, 1'b0);
    check1("R1 sticky", addend_sticky, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      apply(i);
      model(T_SIG[i], T_D[i], T_SUB[i], ef, est, efar);
      check1("R2 out_valid", out_valid, 1'b1);
      check_field($sformatf("R4/R6/R8 field vec %0d", i), aligned_addend, ef);
      check1($sformatf("R5 prod_below vec %0d", i), prod_below, efar);
      check1($sformatf("R7 sticky vec %0d", i), addend_sticky, est);
      check1($sformatf("R9 top bits vec %0d", i), aligned_addend[160] | aligned_addend[159], T_SUB[i]);
    end

    // R2: inputs change with in_valid low; outputs hold, valid drops
    held = aligned_addend;
    @(negedge clk);
    addend_sig = 53'h1FFFFFFFFFFFFF; exp_addend = 11'd2047; exp_mul_a = '0;
    exp_mul_b = '0; eff_sub = 1'b0;
    repeat (2) @(negedge clk);
    check1("R2 valid low", out_valid, 1'b0);
    check_field("R2 hold field", aligned_addend, held);
    check1("R2 hold sticky", addend_sticky, 1'b1);

    // R3: largest negative difference must not wrap into a far-left result
    apply(8);
    check1("R3 no wrap prod_below", prod_below, 1'b0);
    check1("R3 no wrap sticky", addend_sticky, 1'b1);

    // R1: reset applied mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_field("R1 re-reset field", aligned_addend, '0);
    check1("R1 re-reset valid", out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule